// File: doc/BRIEF.md
# Register Increment/Decrement Unit

This unit carries out the increment and decrement operations of a small 8-bit processor core. It owns the working registers: seven byte registers (B, C, D, E, H, L, A), the stack pointer, and a 4-bit flag register. The byte registers pair up as BC, DE and HL. One request picks the operation direction and one of three forms. The byte form updates a register and the flags. The pair form updates a 16-bit pair or the stack pointer and leaves the flags alone. The memory form reads the byte at the address held in HL, modifies it and writes it back through a byte memory port.

Every operation ends with a one-cycle `done` strobe. The strobe carries the cost of the form in processor cycles, so the sequencer around the unit can keep its timing. A load port and a combinational read port give the rest of the core access to the registers. The load port is only open while the unit is idle.

Top module: `incdec_unit`

## Requirements
- R1: A byte-form request (`op_wide`=0) with target code 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A adds or subtracts one (`op_dec`=1 subtracts) modulo 256. The result is in the register and `done` is high in the cycle after acceptance, with `done_cyc`=4.
- R2: In the byte and memory forms, flag Z (bit 3 of `flags`) is set exactly when the result is zero. N (bit 2) becomes 0 for increment and 1 for decrement. C (bit 0) keeps its value.
- R3: In the byte and memory forms, H (bit 1) is set on increment when the low nibble of the operand was 0xF, and on decrement when the low nibble was 0x0. Otherwise it is cleared.
- R4: A pair-form request (`op_wide`=1) with pair code 0=BC, 1=DE, 2=HL, 3=SP adds or subtracts one modulo 65536. `done` is high in the cycle after acceptance, with `done_cyc`=8.
- R5: A pair-form operation leaves all four flags unchanged.
- R6: Target code 6 runs a read-modify-write at address HL. In the cycle after acceptance, `mem_rd` is high and `mem_addr` equals HL. `mem_rdata` is taken one cycle later. In the third cycle, `mem_wr` is high with the modified byte on `mem_wdata`. `done` follows with `done_cyc`=12. Flags change as in R2/R3, and `busy` is high for those three cycles.
- R7: `op_valid` is ignored while `busy` is high.
- R8: The load/read select codes are 0=BC, 1=DE, 2=HL, 3=SP, 4=A with flags. In the last case the A register is the upper byte, and flags Z, N, H, C sit in bits 7..4 with bits 3..0 reading zero. A load is dropped while `busy` is high and in a cycle where `op_valid` is high.
- R9: After reset, all registers and flags are zero, and `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R10: `mem_rd` and `mem_wr` are never high together. Whenever `done` is high, `done_cyc` is one of 4, 8 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request an operation (taken when idle) |
| op_dec | input | 1 | 1 = decrement, 0 = increment |
| op_wide | input | 1 | 1 = pair form, 0 = byte/memory form |
| op_reg | input | 3 | Byte target code (6 = memory at HL) |
| op_pair | input | 2 | Pair target code |
| busy | output | 1 | Memory form in progress |
| done | output | 1 | Operation finished this cycle |
| done_cyc | output | 4 | Processor-cycle cost of the finished operation |
| ld_en | input | 1 | Load a register group |
| ld_sel | input | 3 | Load group select |
| ld_data | input | 16 | Load value |
| rd_sel | input | 3 | Read group select |
| rd_data | output | 16 | Read value (combinational) |
| flags | output | 4 | Flags {Z, N, H, C} |
| mem_addr | output | 16 | Memory address (HL) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after `mem_rd` |

## Verification
A corrupted register or a wrong pair mapping shows on `rd_data` in the same cycle that `done` rises. A wrong flag rule shows on `flags` at that same moment. A fault in the memory sequence shows within three cycles of acceptance, as a strobe in the wrong cycle, a wrong address, or a wrong write byte. A wrongly latched operand appears as a bad `mem_wdata` one cycle before `done`. Dropped-request faults show at the next read of the register a stray request or load would have changed.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

  // control sequence for the memory read-modify-write form
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MRD  = 2'd1,
    ST_MMOD = 2'd2,
    ST_MWR  = 2'd3
  } ctl_state_e;

  // flag register layout, most significant first
  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam int          NUM_BYTES = 8;
  localparam logic [2:0]  CODE_MEM  = 3'd6;
  localparam logic [2:0]  CODE_A    = 3'd7;
  localparam logic [2:0]  GRP_SP    = 3'd3;
  localparam logic [2:0]  GRP_AF    = 3'd4;
  localparam logic [1:0]  PAIR_SP   = 2'd3;

endpackage

// File: rtl/incdec_alu8.sv
module incdec_alu8
  import incdec_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] operand,
  input  logic         dec,
  input  logic         c_in,
  output logic [W-1:0] result,
  output flags_t       flags_out
);

  logic [3:0] low_nib;

  assign low_nib = operand[3:0];

  always_comb begin
    if (dec) begin
      result = operand - W'(1);
    end else begin
      result = operand + W'(1);
    end
    flags_out.z = (result == '0);
    flags_out.n = dec;
    flags_out.h = dec ? (low_nib == 4'h0) : (low_nib == 4'hF);
    flags_out.c = c_in;
  end

endmodule

// File: rtl/incdec_regfile.sv
module incdec_regfile
  import incdec_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr8_en,
  input  logic [2:0]    wr8_idx,
  input  logic [W-1:0]  wr8_data,
  input  logic          wrp_en,
  input  logic [1:0]    wrp_idx,
  input  logic [PW-1:0] wrp_data,
  input  logic          flg_en,
  input  flags_t        flg_data,
  input  logic          ld_en,
  input  logic [2:0]    ld_sel,
  input  logic [PW-1:0] ld_data,
  input  logic [2:0]    rd8_idx,
  output logic [W-1:0]  rd8_data,
  input  logic [1:0]    rdp_idx,
  output logic [PW-1:0] rdp_data,
  input  logic [2:0]    view_sel,
  output logic [PW-1:0] view_data,
  output logic [PW-1:0] hl,
  output flags_t        flags
);

  logic [W-1:0]  byte_q [NUM_BYTES];
  logic [PW-1:0] sp_q, sp_d;
  logic          sp_en;
  flags_t        flg_q, flg_d;
  logic          flg_we;

  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    localparam logic [2:0] IDX     = 3'(gi);
    localparam logic [1:0] PIDX    = 2'(gi / 2);
    localparam bit         IS_PAIR = (gi < 6);
    localparam bit         HIGHB   = ((gi % 2) == 0);

    if (IDX == CODE_MEM) begin : g_hole
      assign byte_q[gi] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      logic [W-1:0] d;
      logic         en;

      always_comb begin
        en = 1'b0;
        d  = q;
        if (wr8_en && wr8_idx == IDX) begin
          en = 1'b1;
          d  = wr8_data;
        end else if (IS_PAIR && wrp_en && wrp_idx == PIDX) begin
          en = 1'b1;
          d  = HIGHB ? wrp_data[PW-1:W] : wrp_data[W-1:0];
        end else if (IS_PAIR && ld_en && ld_sel == {1'b0, PIDX}) begin
          en = 1'b1;
          d  = HIGHB ? ld_data[PW-1:W] : ld_data[W-1:0];
        end else if (!IS_PAIR && ld_en && ld_sel == GRP_AF) begin
          en = 1'b1;
          d  = ld_data[PW-1:W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (en) begin
          q <= d;
        end
      end

      assign byte_q[gi] = q;
    end
  end

  // stack pointer
  always_comb begin
    sp_en = 1'b0;
    sp_d  = sp_q;
    if (wrp_en && wrp_idx == PAIR_SP) begin
      sp_en = 1'b1;
      sp_d  = wrp_data;
    end else if (ld_en && ld_sel == GRP_SP) begin
      sp_en = 1'b1;
      sp_d  = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  // flags
  always_comb begin
    flg_we = 1'b0;
    flg_d  = flg_q;
    if (flg_en) begin
      flg_we = 1'b1;
      flg_d  = flg_data;
    end else if (ld_en && ld_sel == GRP_AF) begin
      flg_we = 1'b1;
      flg_d  = flags_t'(ld_data[W-1 -: 4]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else if (flg_we) begin
      flg_q <= flg_d;
    end
  end

  // read side
  assign rd8_data = byte_q[rd8_idx];
  assign hl       = {byte_q[4], byte_q[5]};
  assign flags    = flg_q;

  always_comb begin
    case (rdp_idx)
      2'd0:    rdp_data = {byte_q[0], byte_q[1]};
      2'd1:    rdp_data = {byte_q[2], byte_q[3]};
      2'd2:    rdp_data = {byte_q[4], byte_q[5]};
      default: rdp_data = sp_q;
    endcase
  end

  always_comb begin
    case (view_sel)
      3'd0:    view_data = {byte_q[0], byte_q[1]};
      3'd1:    view_data = {byte_q[2], byte_q[3]};
      3'd2:    view_data = {byte_q[4], byte_q[5]};
      3'd3:    view_data = sp_q;
      3'd4:    view_data = {byte_q[CODE_A], flg_q, {(W-4){1'b0}}};
      default: view_data = '0;
    endcase
  end

endmodule

// File: rtl/incdec_ctrl.sv
module incdec_ctrl
  import incdec_pkg::*;
#(
  parameter int CYC_REG  = 4,
  parameter int CYC_PAIR = 8,
  parameter int CYC_MEM  = 12,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_wide,
  input  logic [2:0]       op_reg,
  output logic             do_reg,
  output logic             do_pair,
  output logic             mem_start,
  output logic             mem_rd,
  output logic             mem_cap,
  output logic             mem_wr,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] done_cyc
);

  ctl_state_e       st_q, st_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             idle;

  assign idle      = (st_q == ST_IDLE);
  assign do_pair   = idle && op_valid && op_wide;
  assign do_reg    = idle && op_valid && !op_wide && (op_reg != CODE_MEM);
  assign mem_start = idle && op_valid && !op_wide && (op_reg == CODE_MEM);
  assign mem_rd    = (st_q == ST_MRD);
  assign mem_cap   = (st_q == ST_MMOD);
  assign mem_wr    = (st_q == ST_MWR);
  assign busy      = !idle;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (mem_start) st_d = ST_MRD;
      ST_MRD:  st_d = ST_MMOD;
      ST_MMOD: st_d = ST_MWR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = 1'b0;
    cyc_d  = cyc_q;
    if (do_reg) begin
      done_d = 1'b1;
      cyc_d  = CNT_W'(CYC_REG);
    end else if (do_pair) begin
      done_d = 1'b1;
      cyc_d  = CNT_W'(CYC_PAIR);
    end else if (mem_wr) begin
      done_d = 1'b1;
      cyc_d  = CNT_W'(CYC_MEM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      cyc_q  <= cyc_d;
    end
  end

  assign done     = done_q;
  assign done_cyc = cyc_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R10
  cost_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cyc == CNT_W'(CYC_REG) || done_cyc == CNT_W'(CYC_PAIR) ||
              done_cyc == CNT_W'(CYC_MEM)));

  // R6
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 mem_wr);

  // R6
  rmw_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (done && done_cyc == CNT_W'(CYC_MEM)));

endmodule

// File: rtl/incdec_unit.sv
module incdec_unit
  import incdec_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CYC_REG  = 4,
  parameter int CYC_PAIR = 8,
  parameter int CYC_MEM  = 12,
  localparam int PW      = 2 * DATA_W,
  localparam int CNT_W   = $clog2(CYC_MEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_dec,
  input  logic              op_wide,
  input  logic [2:0]        op_reg,
  input  logic [1:0]        op_pair,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  done_cyc,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [PW-1:0]     ld_data,
  input  logic [2:0]        rd_sel,
  output logic [PW-1:0]     rd_data,
  output logic [3:0]        flags,
  output logic [PW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              do_reg, do_pair, mem_start, mem_cap;
  logic              ld_go;
  logic [DATA_W-1:0] rd8_data, alu_in, alu_res;
  logic [PW-1:0]     pair_cur, pair_new, hl;
  flags_t            flg_cur, alu_flg, flg_wr;
  logic              alu_dec, flg_en;

  logic              dec_q, dec_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  flags_t            fpend_q, fpend_d;

  incdec_ctrl #(
    .CYC_REG  (CYC_REG),
    .CYC_PAIR (CYC_PAIR),
    .CYC_MEM  (CYC_MEM),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_wide   (op_wide),
    .op_reg    (op_reg),
    .do_reg    (do_reg),
    .do_pair   (do_pair),
    .mem_start (mem_start),
    .mem_rd    (mem_rd),
    .mem_cap   (mem_cap),
    .mem_wr    (mem_wr),
    .busy      (busy),
    .done      (done),
    .done_cyc  (done_cyc)
  );

  // loads only land while idle and not competing with a request
  assign ld_go = ld_en && !busy && !op_valid;

  assign alu_in  = mem_cap ? mem_rdata : rd8_data;
  assign alu_dec = mem_cap ? dec_q : op_dec;

  incdec_alu8 #(.W(DATA_W)) u_alu (
    .operand   (alu_in),
    .dec       (alu_dec),
    .c_in      (flg_cur.c),
    .result    (alu_res),
    .flags_out (alu_flg)
  );

  assign pair_new = op_dec ? (pair_cur - PW'(1)) : (pair_cur + PW'(1));

  assign flg_en = do_reg || mem_wr;
  assign flg_wr = mem_wr ? fpend_q : alu_flg;

  incdec_regfile #(.W(DATA_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr8_en    (do_reg),
    .wr8_idx   (op_reg),
    .wr8_data  (alu_res),
    .wrp_en    (do_pair),
    .wrp_idx   (op_pair),
    .wrp_data  (pair_new),
    .flg_en    (flg_en),
    .flg_data  (flg_wr),
    .ld_en     (ld_go),
    .ld_sel    (ld_sel),
    .ld_data   (ld_data),
    .rd8_idx   (op_reg),
    .rd8_data  (rd8_data),
    .rdp_idx   (op_pair),
    .rdp_data  (pair_cur),
    .view_sel  (rd_sel),
    .view_data (rd_data),
    .hl        (hl),
    .flags     (flg_cur)
  );

  // memory-form holding registers
  always_comb begin
    dec_d   = dec_q;
    wdat_d  = wdat_q;
    fpend_d = fpend_q;
    if (mem_start) begin
      dec_d = op_dec;
    end
    if (mem_cap) begin
      wdat_d  = alu_res;
      fpend_d = alu_flg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= 1'b0;
      wdat_q  <= '0;
      fpend_q <= '0;
    end else begin
      dec_q   <= dec_d;
      wdat_q  <= wdat_d;
      fpend_q <= fpend_d;
    end
  end

  assign mem_addr  = hl;
  assign mem_wdata = wdat_q;
  assign flags     = flg_cur;

  // R5
  pair_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pair |=> $stable(flg_cur));

  // R2
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_reg |=> (flg_cur.c == $past(flg_cur.c)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hl));

  // R6
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> (mem_rd && mem_addr == $past(hl)));

endmodule

// File: tb/sim_incdec_unit.sv
`timescale 1ns/1ps
module sim_incdec_unit;

  typedef struct {
    logic [3:0]  cyc;
    logic [2:0]  vsel;
    logic [15:0] vval;
    logic [3:0]  fl;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_dec, op_wide;
  logic [2:0]  op_reg;
  logic [1:0]  op_pair;
  logic        busy, done;
  logic [3:0]  done_cyc;
  logic        ld_en;
  logic [2:0]  ld_sel;
  logic [15:0] ld_data;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data;
  logic [3:0]  flags;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  bmem [256];
  logic [7:0]  m8 [8];
  logic [15:0] msp;
  logic [3:0]  mf;
  sb_item_t    sbq [$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc_cnt = 0;

  always #2.5 clk = ~clk;

  incdec_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dec(op_dec),
    .op_wide(op_wide), .op_reg(op_reg), .op_pair(op_pair), .busy(busy),
    .done(done), .done_cyc(done_cyc), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data), .flags(flags),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // byte memory model: read data valid the cycle after the strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
      bmem[8'h40] <= 8'h0F;
      bmem[8'h41] <= 8'h00;
      bmem[8'h42] <= 8'hFF;
      mem_rdata   <= 8'h00;
    end else begin
      if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
      if (mem_wr) bmem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  // shadow model helpers
  function automatic logic [15:0] view_of(input logic [2:0] s);
    case (s)
      3'd0: return {m8[0], m8[1]};
      3'd1: return {m8[2], m8[3]};
      3'd2: return {m8[4], m8[5]};
      3'd3: return msp;
      3'd4: return {m8[7], mf, 4'h0};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [2:0] grp_of(input logic [2:0] code);
    if (code == 3'd7) return 3'd4;
    if (code == 3'd6) return 3'd2;
    return {1'b0, code[2:1]};
  endfunction

  function automatic logic [3:0] flag_of(input logic [7:0] v, input bit dec);
    logic [7:0] r;
    r = dec ? v - 8'd1 : v + 8'd1;
    return {r == 8'd0, dec, dec ? (v[3:0] == 4'h0) : (v[3:0] == 4'hF), mf[0]};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk("R10 unexpected done", 32'd1, 32'd0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        chk({it.tag, " cycles"}, 32'(done_cyc), 32'(it.cyc));
        chk({it.tag, " value"},  32'(rd_data),  32'(it.vval));
        chk({it.tag, " flags"},  32'(flags),    32'(it.fl));
      end
    end
  end

  task automatic load(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    if (s < 3'd3) begin
      m8[2*s] = v[15:8]; m8[2*s+1] = v[7:0];
    end else if (s == 3'd3) begin
      msp = v;
    end else if (s == 3'd4) begin
      m8[7] = v[15:8]; mf = v[7:4];
    end
    rd_sel = s;
    #1 chk("R8 load readback", 32'(rd_data), 32'(view_of(s)));
  endtask

  task automatic byte_op(input bit dec, input logic [2:0] code, input string tag);
    sb_item_t it;
    logic [7:0] v;
    v = m8[code];
    it.fl = flag_of(v, dec);
    m8[code] = dec ? v - 8'd1 : v + 8'd1;
    mf = it.fl;
    it.cyc = 4'd4; it.vsel = grp_of(code); it.vval = view_of(it.vsel); it.tag = tag;
    sbq.push_back(it);
    rd_sel = it.vsel;
    @(negedge clk);
    op_valid = 1'b1; op_dec = dec; op_wide = 1'b0; op_reg = code;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pair_op(input bit dec, input logic [1:0] p, input string tag);
    sb_item_t it;
    logic [15:0] v;
    v = view_of({1'b0, p});
    v = dec ? v - 16'd1 : v + 16'd1;
    if (p == 2'd3) msp = v;
    else begin m8[2*p] = v[15:8]; m8[2*p+1] = v[7:0]; end
    it.cyc = 4'd8; it.vsel = {1'b0, p}; it.vval = v; it.fl = mf; it.tag = tag;
    sbq.push_back(it);
    rd_sel = {1'b0, p};
    @(negedge clk);
    op_valid = 1'b1; op_dec = dec; op_wide = 1'b1; op_pair = p;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic mem_op(input bit dec, input bit inject, input string tag);
    sb_item_t it;
    logic [15:0] a;
    logic [7:0]  v, r;
    a = view_of(3'd2);
    v = bmem[a[7:0]];
    r = dec ? v - 8'd1 : v + 8'd1;
    it.fl = flag_of(v, dec);
    mf = it.fl;
    it.cyc = 4'd12; it.vsel = 3'd2; it.vval = a; it.tag = tag;
    sbq.push_back(it);
    rd_sel = 3'd2;
    @(negedge clk);
    op_valid = 1'b1; op_dec = dec; op_wide = 1'b0; op_reg = 3'd6;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R6 read strobe", 32'({mem_rd, mem_wr, busy}), 32'(3'b101));
    chk("R6 read address", 32'(mem_addr), 32'(a));
    if (inject) begin
      op_valid = 1'b1; op_dec = 1'b0; op_reg = 3'd0;
      ld_en = 1'b1; ld_sel = 3'd2; ld_data = 16'h1234;
    end
    @(negedge clk);
    op_valid = 1'b0; ld_en = 1'b0;
    chk("R6 modify gap", 32'({mem_rd, mem_wr, busy}), 32'(3'b001));
    @(negedge clk);
    chk("R6 write strobe", 32'({mem_rd, mem_wr, busy}), 32'(3'b011));
    chk("R6 write data", 32'(mem_wdata), 32'(r));
    chk("R6 write address", 32'(mem_addr), 32'(a));
    @(negedge clk);
    @(negedge clk);
    chk("R6 idle after", 32'(busy), 32'd0);
    if (inject) begin
      rd_sel = 3'd0;
      #1 chk("R7 request ignored while busy", 32'(rd_data), 32'(view_of(3'd0)));
      rd_sel = 3'd2;
      #1 chk("R8 load ignored while busy", 32'(rd_data), 32'(a));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0; op_dec = 1'b0; op_wide = 1'b0; op_reg = 3'd0; op_pair = 2'd0;
    ld_en = 1'b0; ld_sel = 3'd0; ld_data = 16'h0; rd_sel = 3'd0;
    for (int i = 0; i < 8; i++) m8[i] = 8'h00;
    msp = 16'h0; mf = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int s = 0; s < 5; s++) begin
      rd_sel = 3'(s);
      #1 chk("R9 register reset", 32'(rd_data), 32'd0);
    end
    chk("R9 strobes reset", 32'({busy, done, mem_rd, mem_wr, flags}), 32'd0);

    // R8 loads, AF packs flags {Z,N,H,C} in bits 7..4
    load(3'd0, 16'h12FF);
    load(3'd1, 16'h0F00);
    load(3'd2, 16'h0040);
    load(3'd3, 16'hFFFF);
    load(3'd4, 16'h7F10);

    // R1 R2 R3 byte forms
    byte_op(1'b0, 3'd1, "R1 R3 inc C wrap to zero");
    byte_op(1'b0, 3'd7, "R1 R3 inc A half carry");
    byte_op(1'b1, 3'd2, "R2 dec D");
    byte_op(1'b1, 3'd3, "R3 dec E borrow wrap");
    byte_op(1'b0, 3'd0, "R1 inc B");
    byte_op(1'b0, 3'd5, "R1 inc L");
    byte_op(1'b1, 3'd4, "R1 dec H wrap");
    load(3'd0, 16'h0100);
    byte_op(1'b1, 3'd0, "R2 dec B to zero");
    load(3'd4, 16'h2000);
    byte_op(1'b0, 3'd7, "R2 inc A carry kept clear");

    // R4 R5 pair forms
    pair_op(1'b0, 2'd3, "R4 R5 inc SP wrap");
    pair_op(1'b1, 2'd3, "R4 dec SP wrap");
    pair_op(1'b1, 2'd1, "R4 dec DE");
    pair_op(1'b0, 2'd0, "R4 inc BC");

    // R8 load dropped when a request arrives in the same cycle
    begin
      sb_item_t it;
      logic [7:0] v;
      v = m8[0];
      it.fl = flag_of(v, 1'b0);
      m8[0] = v + 8'd1;
      mf = it.fl;
      it.cyc = 4'd4; it.vsel = 3'd0; it.vval = view_of(3'd0); it.tag = "R1 inc B with load";
      sbq.push_back(it);
      rd_sel = 3'd0;
      @(negedge clk);
      op_valid = 1'b1; op_dec = 1'b0; op_wide = 1'b0; op_reg = 3'd0;
      ld_en = 1'b1; ld_sel = 3'd1; ld_data = 16'hAAAA;
      @(negedge clk);
      op_valid = 1'b0; ld_en = 1'b0;
      @(negedge clk);
      rd_sel = 3'd1;
      #1 chk("R8 load dropped with request", 32'(rd_data), 32'(view_of(3'd1)));
    end

    // R6 memory read-modify-write
    load(3'd2, 16'h0040);
    mem_op(1'b0, 1'b0, "R6 R3 inc mem half carry");
    pair_op(1'b0, 2'd2, "R4 inc HL");
    mem_op(1'b1, 1'b1, "R6 dec mem borrow");
    pair_op(1'b0, 2'd2, "R4 inc HL again");
    mem_op(1'b0, 1'b0, "R6 R2 inc mem to zero");

    repeat (3) @(negedge clk);
    chk("R10 all results seen", 32'(sbq.size()), 32'd0);
    report();
    $finish;
  end

endmodule